// File: doc/BRIEF.md
# NAND Invalid-Block Table Builder

This block runs once after reset. It walks every erase block of a small-page NAND device, with 4096 blocks of 32 pages each, and builds a one-bit-per-block table of invalid blocks. For each block it asks an external page-read engine for one byte. That byte is the factory marker in the spare area, at column 517 of the 528-byte page. The block inspects the byte that comes back. Page 0 is read first. Page 1 is read only when page 0 still shows the erased value FFh. Any other value on either page marks the block as invalid.

Block 0 is guaranteed good by the device. The scan never reads it and records it as good. The block only ever asks for reads, so it can never erase a factory marker. Once the last block is judged, a done flag rises and stays high.

A lookup port returns the bad flag for any block index one cycle after the index is presented. Until the table is complete, every lookup answers "bad", so a client that asks too early treats every block as unusable.

Top module: `bbt_scan`

The controller has four states:

- **BOOT** lasts one cycle after reset and moves to ISSUE. It loads block 1, page 0.
- **ISSUE** holds a read request until it is accepted. It then moves to WAIT.
- **WAIT** waits for the response byte and takes one of three transitions:
  - **mark-and-advance**: the byte is non-FFh, or page 1 was read. The table entry is written and the controller goes to ISSUE for the next block.
  - **finish**: the same as mark-and-advance, but taken on the last block. The controller goes to DONE.
  - **second-page**: page 0 read FFh. The controller goes back to ISSUE for page 1.
- **DONE** is terminal.

## Requirements
- R1: From reset until the scan completes, `scan_done` is 0 and every lookup returns `lk_bad` = 1.
- R2: Each request carries row = block × 32 + page, with page 0 or 1. The column is always 517.
- R3: Block 0 is never requested, and after the scan its lookup returns 0 (good).
- R4: For each block, page 0 is requested first. Page 1 is requested only when the page-0 byte was FFh.
- R5: After the scan, a block reads bad exactly when a returned marker byte for it was not FFh.
- R6: Blocks are requested in ascending order from 1 to 4095, with one request outstanding at a time.
- R7: `scan_done` rises in the cycle after the response that completes block 4095. It then stays high and no further request is raised.
- R8: `lk_bad` reflects the `lk_blk` value sampled at the previous rising clock edge.
- R9: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and its row does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | output | 1 | Read request to the page-read engine |
| rd_req_ready | input | 1 | Request accepted when high together with valid |
| rd_req_row | output | 17 | Page (row) address of the request |
| rd_req_col | output | 10 | Column address of the request (517) |
| rd_rsp_valid | input | 1 | Response byte present |
| rd_rsp_data | input | 8 | Marker byte read from the flash |
| lk_blk | input | 12 | Block index to look up |
| lk_bad | output | 1 | 1 when the looked-up block is bad, or when the table is not ready |
| scan_done | output | 1 | Table complete |

## Verification
The assertions take the read engine to be well behaved in two ways. It returns exactly one response for each accepted request, and it never raises `rd_rsp_valid` while no request is pending. `rd_req_ready` may be held low for any number of cycles.

The bench keeps to these rules with a single responder. That responder accepts a request after a random wait, then returns its byte after a second random wait. Marker bytes come from a seeded hash plus directed cases:

- a non-FFh marker planted on block 0;
- bad page 0 on block 1;
- bad page 1 on block 2;
- near-FFh values on other blocks;
- both end blocks.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } scan_st_t;

endpackage

// File: rtl/bbt_row_calc.sv
// Forms the flash address of one marker read: block and page packed into a
// row, column fixed at the spare-area marker position.
module bbt_row_calc #(
    parameter int BLK_W    = 12,
    parameter int PG_W     = 5,
    parameter int COL_W    = 10,
    parameter int MARK_COL = 517
) (
    input  logic [BLK_W-1:0]       blk,
    input  logic                   pg_sel,
    output logic [BLK_W+PG_W-1:0]  row,
    output logic [COL_W-1:0]       col
);
    always_comb begin
        row = {blk, PG_W'(pg_sel)};
        col = COL_W'(MARK_COL);
    end
endmodule

// File: rtl/bbt_bitmap.sv
// One bit per block; 1 = bad. Cleared at reset (everything good), written
// once per judged block, read through a registered lookup gated by ready.
module bbt_bitmap #(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             wr_bad,
    input  logic             table_ready,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bad
);
    logic [NUM_BLOCKS-1:0] bad_map;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_map <= '0;
        end else if (wr_en) begin
            bad_map[wr_idx] <= wr_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bad <= 1'b1;
        end else begin
            rd_bad <= !table_ready || bad_map[rd_idx];
        end
    end
endmodule

// File: rtl/bbt_scan.sv
module bbt_scan
    import bbt_pkg::*;
#(
    parameter int  NUM_BLOCKS    = 4096,
    parameter int  PAGES_PER_BLK = 32,
    parameter int  MARK_COL      = 517,
    parameter int  COL_W         = 10,
    parameter int  DATA_W        = 8,
    localparam int BLK_W         = $clog2(NUM_BLOCKS),
    localparam int PG_W          = $clog2(PAGES_PER_BLK),
    localparam int ROW_W         = BLK_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ROW_W-1:0]  rd_req_row,
    output logic [COL_W-1:0]  rd_req_col,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic              lk_bad,
    output logic              scan_done
);
    localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(1);
    localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);

    scan_st_t         state, nxt_state;
    logic [BLK_W-1:0] blk, nxt_blk;
    logic             pg, nxt_pg;
    logic             map_we, map_bad;
    logic             erased;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            blk   <= FIRST_BLK;
            pg    <= 1'b0;
        end else begin
            state <= nxt_state;
            blk   <= nxt_blk;
            pg    <= nxt_pg;
        end
    end

    assign erased = (rd_rsp_data == {DATA_W{1'b1}});

    // next state and table write
    always_comb begin
        nxt_state = state;
        nxt_blk   = blk;
        nxt_pg    = pg;
        map_we    = 1'b0;
        map_bad   = 1'b0;
        unique case (state)
            ST_BOOT: begin
                nxt_state = ST_ISSUE;
                nxt_blk   = FIRST_BLK;
                nxt_pg    = 1'b0;
            end
            ST_ISSUE: begin
                if (rd_req_ready) nxt_state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rsp_valid) begin
                    if (!erased || pg) begin
                        map_we  = 1'b1;
                        map_bad = !erased;
                        nxt_pg  = 1'b0;
                        if (blk == LAST_BLK) begin
                            nxt_state = ST_DONE;
                        end else begin
                            nxt_state = ST_ISSUE;
                            nxt_blk   = blk + FIRST_BLK;
                        end
                    end else begin
                        nxt_pg    = 1'b1;
                        nxt_state = ST_ISSUE;
                    end
                end
            end
            ST_DONE: begin
                nxt_state = ST_DONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        rd_req_valid = (state == ST_ISSUE);
        scan_done    = (state == ST_DONE);
    end

    bbt_row_calc #(
        .BLK_W   (BLK_W),
        .PG_W    (PG_W),
        .COL_W   (COL_W),
        .MARK_COL(MARK_COL)
    ) u_row (
        .blk   (blk),
        .pg_sel(pg),
        .row   (rd_req_row),
        .col   (rd_req_col)
    );

    bbt_bitmap #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (map_we),
        .wr_idx     (blk),
        .wr_bad     (map_bad),
        .table_ready(scan_done),
        .rd_idx     (lk_blk),
        .rd_bad     (lk_bad)
    );
endmodule

// File: rtl/bbt_scan_chk.sv
module bbt_scan_chk #(
    parameter int NUM_BLOCKS    = 4096,
    parameter int PAGES_PER_BLK = 32,
    parameter int ROW_W         = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [ROW_W-1:0] rd_req_row,
    input logic             lk_bad,
    input logic             scan_done
);
    localparam int PG_W = $clog2(PAGES_PER_BLK);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_row))); // R9

    AST_NO_BLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_row >= ROW_W'(PAGES_PER_BLK))); // R3

    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_row[PG_W-1:0] <= PG_W'(1))); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !rd_req_valid); // R7

    AST_EARLY_LOOKUP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |=> lk_bad); // R1
endmodule

bind bbt_scan bbt_scan_chk #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .ROW_W        (ROW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_row  (rd_req_row),
    .lk_bad      (lk_bad),
    .scan_done   (scan_done)
);

// File: tb/bbt_scan_test.sv
`timescale 1ns/1ps
module bbt_scan_test;
    localparam int NB   = 4096;
    localparam int PPB  = 32;
    localparam int COL  = 517;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [16:0] rd_req_row;
    logic [9:0]  rd_req_col;
    logic        rd_rsp_valid = 1'b0;
    logic [7:0]  rd_rsp_data = 8'h00;
    logic [11:0] lk_blk = '0;
    logic        lk_bad;
    logic        scan_done;

    int checks = 0;
    int fails  = 0;
    bit scan_over = 1'b0;
    bit finished  = 1'b0;

    always #2 clk = ~clk;

    bbt_scan uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .lk_blk(lk_blk), .lk_bad(lk_bad), .scan_done(scan_done)
    );

    // marker byte the modelled flash holds for (block, page)
    function automatic logic [7:0] mark_byte(int blk, int pg);
        int unsigned h;
        if (blk == 0)                return 8'h00;   // would be bad if ever read
        if (blk == 1    && pg == 0)  return 8'h00;
        if (blk == 2    && pg == 1)  return 8'hA5;
        if (blk == 3    && pg == 0)  return 8'hFE;
        if (blk == 5    && pg == 1)  return 8'h7F;
        if (blk == 4094 && pg == 0)  return 8'h7F;
        if (blk == 4095 && pg == 1)  return 8'hEF;
        if (blk == 4 || blk == 4093) return 8'hFF;
        h = int'(blk) * 32'd1103515245 + int'(pg) * 32'd12345 + 32'd777;
        if (((h >> 16) % 9) == 0) return 8'(h >> 5) & 8'h7F;
        return 8'hFF;
    endfunction

    function automatic bit exp_bad(int blk);
        if (blk == 0) return 1'b0;
        return (mark_byte(blk, 0) != 8'hFF) || (mark_byte(blk, 1) != 8'hFF);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // read-engine model: accepts each request, returns the marker byte
    initial begin
        int eb = 1;
        int ep = 0;
        logic [7:0] d;
        void'($urandom(32'd2024));
        @(posedge rst_n);
        while (!scan_over) begin
            @(negedge clk);
            if (rd_req_valid) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                // R2 R4 R6: expected row in scan order
                check(int'(rd_req_row) == eb * PPB + ep, "R2/R4/R6 row", int'(rd_req_row), eb * PPB + ep);
                check(int'(rd_req_col) == COL, "R2 col", int'(rd_req_col), COL);
                rd_req_ready = 1'b1;
                @(negedge clk);
                rd_req_ready = 1'b0;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                check(rd_req_valid == 1'b0, "R6 single outstanding", int'(rd_req_valid), 0);
                check(scan_done == 1'b0, "R7 done not early", int'(scan_done), 0);
                d = mark_byte(eb, ep);
                rd_rsp_data  = d;
                rd_rsp_valid = 1'b1;
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                rd_rsp_data  = $urandom_range(0, 255);
                if (d != 8'hFF || ep == 1) begin
                    eb++;
                    ep = 0;
                end else begin
                    ep = 1;
                end
                if (eb == NB) begin
                    check(scan_done == 1'b1, "R7 done after last", int'(scan_done), 1);
                    scan_over = 1'b1;
                end
            end
        end
    end

    // main sequence
    initial begin
        repeat (3) @(negedge clk);
        check(scan_done == 1'b0, "R1 reset done", int'(scan_done), 0);
        check(rd_req_valid == 1'b0, "R1 reset valid", int'(rd_req_valid), 0);
        check(lk_bad == 1'b1, "R1 reset lookup", int'(lk_bad), 1);
        rst_n = 1'b1;
        // R1: lookups during the scan answer bad
        for (int i = 0; i < 8; i++) begin
            lk_blk = (i == 0) ? 12'd0 : 12'($urandom_range(0, NB - 1));
            @(negedge clk);
            check(lk_bad == 1'b1, "R1 lookup before done", int'(lk_bad), 1);
        end
        wait (scan_over);
        // R7: no further requests, done stays high
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(rd_req_valid == 1'b0 && scan_done == 1'b1, "R7 quiet after done",
                  int'({rd_req_valid, scan_done}), 1);
        end
        // R3: block 0 good despite a bad marker in the model
        lk_blk = 12'd0;
        @(negedge clk);
        check(lk_bad == 1'b0, "R3 block zero good", int'(lk_bad), 0);
        // R5 R8: full sweep, one-cycle latency
        for (int b = 0; b < NB; b++) begin
            lk_blk = 12'(b);
            @(negedge clk);
            check(lk_bad == exp_bad(b), "R5/R8 table entry", int'(lk_bad), int'(exp_bad(b)));
        end
        // R8: random order lookups
        for (int i = 0; i < 64; i++) begin
            int b = $urandom_range(0, NB - 1);
            lk_blk = 12'(b);
            @(negedge clk);
            check(lk_bad == exp_bad(b), "R8 random lookup", int'(lk_bad), int'(exp_bad(b)));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule